// File: doc/BRIEF.md
# Serial Flash Read Responder

This block plays the slave side of a serial flash on a four-wire SPI link (mode 0). It answers only the read command, which it serves from a small internal byte store. A chip-select frame opens with a command byte. For a read, three address bytes follow, and then as many data bytes as the host clocks out. The data bytes come from consecutive store locations.

The store is filled before use through a plain synchronous write port. A testbench or a system model preloads it with the image that the host is meant to see. All link inputs are sampled by the block's own clock, which has to run well above the serial clock. The block detects the serial clock edges itself: it captures input bits on the rising edge and moves the outgoing byte on the falling edge.

Top module: `spiflash_read_responder`

## Requirements
- R1: While `spi_cs_n` is high, and from reset onward, `spi_miso` is 0.
- R2: The first byte of every frame is taken as the command byte, and `spi_miso` is 0 while it is transferred.
- R3: Command value 0x03 selects read; the three following bytes form a 24-bit address, first byte most significant.
- R4: `spi_miso` is 0 during all three address bytes.
- R5: Each byte after the address returns the stored byte at the current address, most significant bit first, and the address then advances by one.
- R6: Any address at or above `MEM_BYTES` returns 0.
- R7: Raising `spi_cs_n` ends the frame at once; the next byte after it falls again is decoded as a new command.
- R8: Any command other than 0x03 leaves `spi_miso` at 0 for the rest of that frame.
- R9: The address counter is 24 bits wide and goes from 0xFFFFFF to 0x000000.
- R10: A cycle with `pre_wr_en` high stores `pre_wr_data` at location `pre_wr_idx`, and later reads return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; oversamples the serial link |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| pre_wr_en | input | 1 | Preload write strobe |
| pre_wr_idx | input | IDX_W (8) | Preload byte location |
| pre_wr_data | input | 8 | Preload byte value |

## Verification
The assertions rest on three assumptions about the inputs. All link inputs are synchronous to `clk`. Each level of `spi_sck` lasts at least three clock cycles, which leaves time for the load of the response byte before the next falling edge. `spi_cs_n` changes only while `spi_sck` is low. The bench drives the link from a task that holds every serial clock phase for four cycles and moves select only with the clock low, so the stimulus stays inside those limits. It never preloads the store during a frame.

// File: rtl/spiflash_pkg.sv
package spiflash_pkg;
   typedef enum logic [1:0] {
      PH_CMD  = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2,
      PH_IDLE = 2'd3
   } phase_t;
endpackage

// File: rtl/spiflash_shifter.sv
module spiflash_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              cs_n,
   input  logic              mosi,
   output logic              miso,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_byte,
   output logic              byte_done,
   output logic [BYTE_W-1:0] rx_byte
);
   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

   if (BYTE_W < 2) begin : g_bad_width
      $error("spiflash_shifter: BYTE_W must be at least 2");
   end

   logic              sck_q;
   logic              rise, fall;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] rx_q, tx_q;

   assign rise = sck & ~sck_q;
   assign fall = ~sck & sck_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sck_q     <= 1'b0;
         bit_cnt   <= '0;
         rx_q      <= '0;
         tx_q      <= '0;
         byte_done <= 1'b0;
      end else begin
         sck_q     <= sck;
         byte_done <= 1'b0;
         if (cs_n) begin
            bit_cnt <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
         end else begin
            if (rise) begin
               rx_q <= {rx_q[BYTE_W-2:0], mosi};
               if (bit_cnt == LAST) begin
                  bit_cnt   <= '0;
                  byte_done <= 1'b1;
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
            if (load)
               tx_q <= load_byte;
            else if (fall && bit_cnt != '0)
               tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
         end
      end
   end

   assign rx_byte = rx_q;
   assign miso    = cs_n ? 1'b0 : tx_q[BYTE_W-1];

   // R7: a released select empties the byte machinery before the next frame
   p_frame_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (bit_cnt == '0 && tx_q == '0));

   // R5: the outgoing byte never moves across a byte boundary
   p_no_shift_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && fall && !load && bit_cnt == '0) |=> $stable(tx_q));
endmodule

// File: rtl/spiflash_mem.sv
module spiflash_mem #(
   parameter int MEM_BYTES = 256,
   parameter int ADDR_W    = 24,
   parameter int DATA_W    = 8,
   localparam int IDX_W    = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   if (MEM_BYTES < 1 || IDX_W > ADDR_W) begin : g_bad_size
      $error("spiflash_mem: MEM_BYTES out of range for ADDR_W");
   end

   logic [DATA_W-1:0] store [MEM_BYTES];

   always_ff @(posedge clk) begin
      if (wr_en && ({1'b0, wr_idx} < (IDX_W+1)'(MEM_BYTES)))
         store[wr_idx] <= wr_data;
   end

   if (IDX_W == ADDR_W && MEM_BYTES == (1 << IDX_W)) begin : g_full_span
      assign rd_data = store[rd_addr[IDX_W-1:0]];
   end else begin : g_bounded
      logic in_range;
      assign in_range = ({1'b0, rd_addr} < (ADDR_W+1)'(MEM_BYTES));
      assign rd_data  = in_range ? store[rd_addr[IDX_W-1:0]] : '0;
   end
endmodule

// File: rtl/spiflash_ctrl.sv
module spiflash_ctrl
   import spiflash_pkg::*;
#(
   parameter int          ADDR_BYTES = 3,
   parameter int          BYTE_W     = 8,
   parameter logic [7:0]  READ_CMD   = 8'h03,
   localparam int         ADDR_W     = ADDR_BYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              byte_done,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [BYTE_W-1:0] mem_data,
   output logic              load,
   output logic [BYTE_W-1:0] load_byte
);
   localparam int ACNT_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
   localparam logic [ACNT_W-1:0] ALAST = ACNT_W'(ADDR_BYTES - 1);

   if (ADDR_BYTES < 2 || BYTE_W != 8) begin : g_bad_cfg
      $error("spiflash_ctrl: need ADDR_BYTES >= 2 and BYTE_W == 8");
   end

   phase_t             phase;
   logic [ACNT_W-1:0]  acnt;
   logic [ADDR_W-1:0]  addr_q;
   logic [ADDR_W-1:0]  assembled;
   logic               last_addr;

   assign assembled = {addr_q[ADDR_W-BYTE_W-1:0], rx_byte};
   assign last_addr = (phase == PH_ADDR) && (acnt == ALAST);
   assign mem_addr  = (phase == PH_DATA) ? addr_q : assembled;
   assign load      = byte_done && !cs_n;

   always_comb begin
      load_byte = '0;
      if (last_addr || phase == PH_DATA)
         load_byte = mem_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || cs_n) begin
         phase  <= PH_CMD;
         acnt   <= '0;
         addr_q <= '0;
      end else if (byte_done) begin
         unique case (phase)
            PH_CMD: begin
               phase  <= (rx_byte == READ_CMD) ? PH_ADDR : PH_IDLE;
               acnt   <= '0;
               addr_q <= '0;
            end
            PH_ADDR: begin
               if (acnt == ALAST) begin
                  addr_q <= assembled + 1'b1;
                  phase  <= PH_DATA;
               end else begin
                  addr_q <= assembled;
               end
               acnt <= acnt + 1'b1;
            end
            PH_DATA: addr_q <= addr_q + 1'b1;
            PH_IDLE: ;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R7: every released select returns the decoder to the command phase
   p_new_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> phase == PH_CMD);

   // R8: an unknown command stays ignored until the frame ends
   p_ignore_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && !cs_n) |=> phase == PH_IDLE);

   // R4: no response data is queued while address bytes are still due
   p_addr_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (load && (phase == PH_CMD || (phase == PH_ADDR && acnt != ALAST))) |-> load_byte == '0);

   // R5 / R9: each served data byte advances the 24-bit address by one, modulo 2^24
   p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && !cs_n && phase == PH_DATA) |=> addr_q == $past(addr_q) + 1'b1);
endmodule

// File: rtl/spiflash_read_responder.sv
module spiflash_read_responder #(
   parameter int         MEM_BYTES  = 256,
   parameter int         ADDR_BYTES = 3,
   parameter logic [7:0] READ_CMD   = 8'h03,
   localparam int        BYTE_W     = 8,
   localparam int        ADDR_W     = ADDR_BYTES * BYTE_W,
   localparam int        IDX_W      = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   input  logic              pre_wr_en,
   input  logic [IDX_W-1:0]  pre_wr_idx,
   input  logic [BYTE_W-1:0] pre_wr_data
);
   logic              byte_done;
   logic [BYTE_W-1:0] rx_byte;
   logic              load;
   logic [BYTE_W-1:0] load_byte;
   logic [ADDR_W-1:0] mem_addr;
   logic [BYTE_W-1:0] mem_data;

   spiflash_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck       (spi_sck),
      .cs_n      (spi_cs_n),
      .mosi      (spi_mosi),
      .miso      (spi_miso),
      .load      (load),
      .load_byte (load_byte),
      .byte_done (byte_done),
      .rx_byte   (rx_byte)
   );

   spiflash_ctrl #(
      .ADDR_BYTES (ADDR_BYTES),
      .BYTE_W     (BYTE_W),
      .READ_CMD   (READ_CMD)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (spi_cs_n),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .mem_addr  (mem_addr),
      .mem_data  (mem_data),
      .load      (load),
      .load_byte (load_byte)
   );

   spiflash_mem #(
      .MEM_BYTES (MEM_BYTES),
      .ADDR_W    (ADDR_W),
      .DATA_W    (BYTE_W)
   ) u_mem (
      .clk     (clk),
      .wr_en   (pre_wr_en),
      .wr_idx  (pre_wr_idx),
      .wr_data (pre_wr_data),
      .rd_addr (mem_addr),
      .rd_data (mem_data)
   );

   // R1: the data line stays quiet while no frame is open
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |=> (spi_cs_n -> !spi_miso));
endmodule

// File: tb/spiflash_read_responder_tb.sv
`timescale 1ns/1ps
module spiflash_read_responder_tb;
   localparam int MEMN = 256;
   localparam int HALF = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic       miso;
   logic       wr_en = 1'b0;
   logic [7:0] wr_idx = '0, wr_data = '0;

   int n_run = 0, n_fail = 0;
   bit done = 0;
   logic [7:0] model [MEMN];

   always #2.5 clk = ~clk;

   spiflash_read_responder u_dut (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
      .spi_mosi(mosi), .spi_miso(miso), .pre_wr_en(wr_en),
      .pre_wr_idx(wr_idx), .pre_wr_data(wr_data)
   );

   // table of reads: {start address, byte count}
   localparam logic [27:0] VEC [6] = '{
      {24'h000000, 4'd4}, {24'h000010, 4'd3}, {24'h000080, 4'd6},
      {24'h0000FC, 4'd6}, {24'h000100, 4'd2}, {24'hFFFFFE, 4'd4}
   };

   function automatic logic [7:0] expect_at(input logic [23:0] a);
      return (a < 24'(MEMN)) ? model[a[7:0]] : 8'h00;
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         mosi = tx[i];
         repeat (HALF) @(negedge clk);
         rx[i] = miso;
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   task automatic open_frame();
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic close_frame();
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic preload(input logic [7:0] idx, input logic [7:0] val);
      wr_en = 1'b1; wr_idx = idx; wr_data = val;
      @(negedge clk);
      wr_en = 1'b0;
      model[idx] = val;
   endtask

   // opens a read frame, checks the silent command and address bytes
   task automatic start_read(input logic [23:0] a, input string tag);
      logic [7:0] r;
      open_frame();
      xfer(8'h03, r);
      check({tag, "/R2 cmd byte"}, r, 8'h00);
      xfer(a[23:16], r); check({tag, "/R4 addr hi"}, r, 8'h00);
      xfer(a[15:8],  r); check({tag, "/R4 addr mid"}, r, 8'h00);
      xfer(a[7:0],   r); check({tag, "/R4 addr lo"}, r, 8'h00);
   endtask

   task automatic read_bytes(input logic [23:0] a, input int n, input string tag);
      logic [7:0] r;
      logic [23:0] cur;
      cur = a;
      for (int k = 0; k < n; k++) begin
         xfer(8'hFF, r);
         check(tag, r, expect_at(cur));
         cur = cur + 24'd1;
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] r;
      repeat (3) @(negedge clk);
      check("R1 miso in reset", {7'd0, miso}, 8'h00);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 miso after reset", {7'd0, miso}, 8'h00);

      for (int i = 0; i < MEMN; i++) preload(8'(i), 8'((i * 37 + 11) & 8'hFF));

      // vector table walk: R3, R5, R6, R9 across start points
      for (int v = 0; v < 6; v++) begin
         start_read(VEC[v][27:4], "R3 table");
         read_bytes(VEC[v][27:4], int'(VEC[v][3:0]), "R5 table data");
         close_frame();
      end

      // R3: the first address byte is the most significant one
      start_read(24'h010020, "R3");
      read_bytes(24'h010020, 2, "R3 high byte selects out of range");
      close_frame();

      // R6: crossing the end of the store
      start_read(24'h0000FF, "R6");
      read_bytes(24'h0000FF, 3, "R6 past end reads zero");
      close_frame();

      // R9: 24-bit address wrap
      start_read(24'hFFFFFF, "R9");
      read_bytes(24'hFFFFFF, 2, "R9 wrap to zero");
      close_frame();

      // R8: unknown command stays silent
      open_frame();
      xfer(8'h9F, r); check("R8 cmd byte", r, 8'h00);
      for (int k = 0; k < 5; k++) begin
         xfer(8'h00, r); check("R8 ignored command", r, 8'h00);
      end
      close_frame();

      // R7: abort mid-data, then a fresh command
      start_read(24'h000020, "R7 first");
      read_bytes(24'h000020, 2, "R7 before release");
      close_frame();
      check("R1 miso released", {7'd0, miso}, 8'h00);
      start_read(24'h000040, "R7 second");
      read_bytes(24'h000040, 2, "R7 new frame data");
      close_frame();

      // R10: preload overwrite is visible
      preload(8'h05, 8'hA5);
      start_read(24'h000005, "R10");
      read_bytes(24'h000004, 0, "R10");
      xfer(8'hFF, r); check("R10 overwritten byte", r, 8'hA5);
      close_frame();

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule